// File: doc/BRIEF.md
# Interrupt Register Bank Save Controller

This block tracks which of fifteen fast register-save banks are occupied while interrupts nest. On interrupt entry the CPU raises a save strobe, and the controller answers with the index of the bank to write. On interrupt return it raises a restore strobe, and the controller names the bank to read. Banks are filled and emptied last-in first-out, so the most recently written bank is always the first one read back. The register storage and the stack memory sit outside the block; the controller only drives their enables and the bank index.

When all fifteen banks hold data, a further save has two possible outcomes, chosen by the overflow-enable control. With the control set, the save raises a bank-overflow exception. With it clear, the save spills to the stack and the use-stack flag is raised. The controller counts spilled saves, and later restores drain the stack before any bank is read. A restore with nothing saved anywhere raises a bank-underflow exception.

The controller is a four-state machine. ST_EMPTY means no bank is used. ST_PARTIAL means some banks are used but not all. ST_FULL means every bank is used and nothing is spilled. ST_SPILL means every bank is used and at least one save went to the stack. The transitions are:
- ST_EMPTY to ST_PARTIAL on a save (or straight to ST_FULL when only one bank exists).
- ST_PARTIAL to ST_FULL on the save that takes the last free bank.
- ST_PARTIAL to ST_EMPTY on the restore that frees the last used bank.
- ST_FULL to ST_SPILL on a save with overflow reporting disabled.
- ST_FULL to ST_PARTIAL on a restore.
- ST_SPILL to ST_FULL on the restore that drains the last stacked save.

Every other accepted operation keeps the current state.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, bank_idx is 0 and bank_wr_en, bank_rd_en, use_stack, ovf_exc and unf_exc are all 0.
- R2: A save at a non-zero irq_level while fewer than 15 banks are used pulses bank_wr_en in the next cycle. bank_idx then equals the number of banks used before the save, so the first save after reset uses index 0.
- R3: A restore while banks are used and no save is on the stack pulses bank_rd_en in the next cycle. bank_idx then names the most recently written bank that has not yet been read.
- R4: A save at a non-zero level while all 15 banks are used and ovf_en is 1 pulses ovf_exc in the next cycle. No bank is written, and the bank and stack counts stay unchanged.
- R5: A save at a non-zero level while all 15 banks are used and ovf_en is 0 pulses use_stack in the next cycle. No bank is written, and the stacked-save count grows by one.
- R6: A restore while the stacked-save count is non-zero pulses use_stack in the next cycle. No bank is read, and the count shrinks by one. Stacked saves are always restored before any bank.
- R7: A restore while no bank is used and no save is stacked pulses unf_exc in the next cycle and reads nothing.
- R8: A save with irq_level equal to 0 is ignored. No output pulses, and the bank and stack counts stay unchanged.
- R9: When save_req and restore_req are high in the same cycle, restore_req is ignored and only the save takes effect.
- R10: The stacked-save count saturates at 255. A save that would need the stack while it holds 255 entries pulses ovf_exc whatever ovf_en is.
- R11: Each of bank_wr_en, bank_rd_en, use_stack, ovf_exc and unf_exc is high for exactly one cycle per accepted operation, and at most one of them is high in any cycle. bank_idx keeps its value when neither a bank write nor a bank read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| save_req | input | 1 | Interrupt-entry save strobe |
| restore_req | input | 1 | Interrupt-return restore strobe |
| irq_level | input | 4 | Priority level of the interrupt being entered; 0 means no interrupt |
| ovf_en | input | 1 | 1: a save with all banks full raises ovf_exc; 0: it spills to the stack |
| bank_idx | output | 4 | Bank to write or read, valid with bank_wr_en or bank_rd_en |
| bank_wr_en | output | 1 | One-cycle write enable for bank bank_idx |
| bank_rd_en | output | 1 | One-cycle read enable for bank bank_idx |
| use_stack | output | 1 | One-cycle pulse: this save or restore uses the stack |
| ovf_exc | output | 1 | One-cycle bank-overflow exception strobe |
| unf_exc | output | 1 | One-cycle bank-underflow exception strobe |

## Verification
The hardest condition to reach from the ports is a saturated stack with all banks full. Reaching it takes fifteen saves to fill the banks and then 255 saves with overflow reporting disabled. The stimulus does exactly that, then sends one more save with ovf_en still 0 and checks that it turns into an overflow exception. The stack is then drained by 255 restores, and the bench confirms that the next restore reads bank 14. Along the way, the bench checks a save at level 0 and a save and restore raised together, each at a fill level where the wrong answer would move the bank index.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2,
        ST_SPILL   = 2'd3
    } rb_state_t;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_READ    = 3'd2,
        OP_SPILL   = 3'd3,
        OP_UNSPILL = 3'd4,
        OP_OVF     = 3'd5,
        OP_UNF     = 3'd6
    } rb_op_t;

endpackage

// File: rtl/rbank_ctr.sv
module rbank_ctr #(
    parameter int W   = 4,
    parameter int MAX = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         is_zero,
    output logic         is_one,
    output logic         is_max
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (inc && !dec)
            count <= count + W'(1);
        else if (dec && !inc)
            count <= count - W'(1);
    end

    assign is_zero = (count == '0);
    assign is_one  = (count == W'(1));
    assign is_max  = (count == W'(MAX));

    AST_CTR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) !(inc && is_max) && !(dec && is_zero)) else $error("counter wrap"); // R10

endmodule

// File: rtl/rbank_op_decode.sv
module rbank_op_decode
    import rbank_pkg::*;
(
    input  rb_state_t state,
    input  logic      save_v,
    input  logic      rest_v,
    input  logic      ovf_en,
    input  logic      spill_max,
    output rb_op_t    op
);

    always_comb begin
        op = OP_NONE;
        unique case (state)
            ST_EMPTY: begin
                if (save_v)      op = OP_WRITE;
                else if (rest_v) op = OP_UNF;
            end
            ST_PARTIAL: begin
                if (save_v)      op = OP_WRITE;
                else if (rest_v) op = OP_READ;
            end
            ST_FULL: begin
                if (save_v)      op = ovf_en ? OP_OVF : OP_SPILL;
                else if (rest_v) op = OP_READ;
            end
            ST_SPILL: begin
                if (save_v)      op = (ovf_en || spill_max) ? OP_OVF : OP_SPILL;
                else if (rest_v) op = OP_UNSPILL;
            end
        endcase
    end

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import rbank_pkg::*;
#(
    parameter int NUM_BANKS = 15,
    parameter int SPILL_W   = 8,
    parameter int LVL_W     = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               save_req,
    input  logic                               restore_req,
    input  logic [LVL_W-1:0]                   irq_level,
    input  logic                               ovf_en,
    output logic [$clog2(NUM_BANKS+1)-1:0]     bank_idx,
    output logic                               bank_wr_en,
    output logic                               bank_rd_en,
    output logic                               use_stack,
    output logic                               ovf_exc,
    output logic                               unf_exc
);

    localparam int CNT_W     = $clog2(NUM_BANKS + 1);
    localparam int SPILL_MAX = (1 << SPILL_W) - 1;

    rb_state_t           state, state_nxt;
    rb_op_t              op;
    logic                save_v, rest_v;
    logic [CNT_W-1:0]    fill_cnt;
    logic                fill_zero, fill_one, fill_max;
    logic [SPILL_W-1:0]  spill_depth;
    logic                spill_zero, spill_one, spill_max;

    // A save needs a real interrupt level; a save in the same cycle masks a restore.
    assign save_v = save_req && (irq_level != '0);
    assign rest_v = restore_req && !save_req;

    rbank_op_decode u_dec (
        .state     (state),
        .save_v    (save_v),
        .rest_v    (rest_v),
        .ovf_en    (ovf_en),
        .spill_max (spill_max),
        .op        (op)
    );

    rbank_ctr #(.W(CNT_W), .MAX(NUM_BANKS)) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (op == OP_WRITE),
        .dec     (op == OP_READ),
        .count   (fill_cnt),
        .is_zero (fill_zero),
        .is_one  (fill_one),
        .is_max  (fill_max)
    );

    rbank_ctr #(.W(SPILL_W), .MAX(SPILL_MAX)) u_spill (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (op == OP_SPILL),
        .dec     (op == OP_UNSPILL),
        .count   (spill_depth),
        .is_zero (spill_zero),
        .is_one  (spill_one),
        .is_max  (spill_max)
    );

    // Next state
    always_comb begin
        state_nxt = state;
        case (op)
            OP_WRITE:   state_nxt = (fill_cnt == CNT_W'(NUM_BANKS - 1)) ? ST_FULL : ST_PARTIAL;
            OP_READ:    state_nxt = fill_one ? ST_EMPTY : ST_PARTIAL;
            OP_SPILL:   state_nxt = ST_SPILL;
            OP_UNSPILL: state_nxt = spill_one ? ST_FULL : ST_SPILL;
            default:    state_nxt = state;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_idx   <= '0;
            bank_wr_en <= 1'b0;
            bank_rd_en <= 1'b0;
            use_stack  <= 1'b0;
            ovf_exc    <= 1'b0;
            unf_exc    <= 1'b0;
        end else begin
            bank_wr_en <= (op == OP_WRITE);
            bank_rd_en <= (op == OP_READ);
            use_stack  <= (op == OP_SPILL) || (op == OP_UNSPILL);
            ovf_exc    <= (op == OP_OVF);
            unf_exc    <= (op == OP_UNF);
            if (op == OP_WRITE)
                bank_idx <= fill_cnt;
            else if (op == OP_READ)
                bank_idx <= fill_cnt - CNT_W'(1);
        end
    end

    AST_WR_FREE: assert property (@(posedge clk) disable iff (!rst_n) (save_v && !fill_max) |=> (bank_wr_en && bank_idx == $past(fill_cnt))) else $error("write"); // R2
    AST_RD_LIFO: assert property (@(posedge clk) disable iff (!rst_n) (rest_v && !fill_zero && spill_zero) |=> (bank_rd_en && bank_idx == $past(fill_cnt) - CNT_W'(1))) else $error("read"); // R3
    AST_OVF_EN: assert property (@(posedge clk) disable iff (!rst_n) (save_v && fill_max && ovf_en) |=> (ovf_exc && !bank_wr_en)) else $error("ovf"); // R4
    AST_SPILL_GROW: assert property (@(posedge clk) disable iff (!rst_n) (save_v && fill_max && !ovf_en && !spill_max) |=> (use_stack && spill_depth == $past(spill_depth) + SPILL_W'(1))) else $error("spill"); // R5
    AST_STACK_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (rest_v && !spill_zero) |=> (use_stack && !bank_rd_en)) else $error("unspill"); // R6
    AST_SPILL_STATE: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_SPILL) |-> (!spill_zero && fill_max)) else $error("spill state"); // R6
    AST_UNF: assert property (@(posedge clk) disable iff (!rst_n) (rest_v && fill_zero && spill_zero) |=> unf_exc) else $error("unf"); // R7
    AST_LVL0: assert property (@(posedge clk) disable iff (!rst_n) (save_req && irq_level == '0) |=> (!bank_wr_en && !bank_rd_en && !use_stack && !ovf_exc && !unf_exc)) else $error("lvl0"); // R8
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({bank_wr_en, bank_rd_en, use_stack, ovf_exc, unf_exc})) else $error("multi"); // R11
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!bank_wr_en && !bank_rd_en) |-> $stable(bank_idx)) else $error("idx"); // R11

endmodule

// File: tb/sim_irq_bank_ctrl.sv
module sim_irq_bank_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 15;
    localparam int SMAX       = 255;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       save_req = 1'b0;
    logic       restore_req = 1'b0;
    logic [3:0] irq_level = 4'd0;
    logic       ovf_en = 1'b0;
    logic [3:0] bank_idx;
    logic       bank_wr_en, bank_rd_en, use_stack, ovf_exc, unf_exc;

    irq_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
        .irq_level(irq_level), .ovf_en(ovf_en), .bank_idx(bank_idx),
        .bank_wr_en(bank_wr_en), .bank_rd_en(bank_rd_en), .use_stack(use_stack),
        .ovf_exc(ovf_exc), .unf_exc(unf_exc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Reference model state
    int   m_banks = 0;
    int   m_stack = 0;
    logic [3:0] e_idx = 4'd0;
    logic e_wr = 0, e_rd = 0, e_stk = 0, e_ovf = 0, e_unf = 0;

    task automatic compare(input string tag);
        logic [8:0] act, exp;
        act = {bank_idx, bank_wr_en, bank_rd_en, use_stack, ovf_exc, unf_exc};
        exp = {e_idx, e_wr, e_rd, e_stk, e_ovf, e_unf};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: idx/wr/rd/stk/ovf/unf actual=%h_%b expected=%h_%b",
                     tag, act[8:5], act[4:0], exp[8:5], exp[4:0]);
        end
    endtask

    // Drive at a falling edge, model the rising edge, compare at the next falling edge.
    task automatic step(input logic s, input logic r, input logic [3:0] lvl,
                        input logic en, input string tag);
        save_req = s; restore_req = r; irq_level = lvl; ovf_en = en;
        @(posedge clk);
        e_wr = 0; e_rd = 0; e_stk = 0; e_ovf = 0; e_unf = 0;
        if (s && lvl != 0) begin
            if (m_banks < NB) begin
                e_wr = 1; e_idx = 4'(m_banks); m_banks++;
            end else if (en || m_stack == SMAX) begin
                e_ovf = 1;
            end else begin
                e_stk = 1; m_stack++;
            end
        end else if (r && !s) begin
            if (m_stack > 0) begin
                e_stk = 1; m_stack--;
            end else if (m_banks > 0) begin
                m_banks--; e_rd = 1; e_idx = 4'(m_banks);
            end else begin
                e_unf = 1;
            end
        end
        @(negedge clk);
        save_req = 0; restore_req = 0; irq_level = 0;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 4'd0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset state");
        rst_n = 1;
        @(negedge clk);
        compare("R1 after release");

        step(0, 1, 4'd0, 0, "R7 restore on empty");
        idle("R11 pulse ends");

        for (int i = 0; i < 5; i++) step(1, 0, 4'd3, 0, "R2 save into free bank");
        step(1, 0, 4'd0, 1, "R8 level-0 save ignored");
        idle("R11 idx holds");
        step(0, 1, 4'd0, 0, "R3 restore reads bank 4 after level-0 save");
        step(1, 1, 4'd2, 0, "R9 save wins over restore");
        step(1, 1, 4'd0, 0, "R9 R8 level-0 save masks restore");
        step(0, 1, 4'd0, 0, "R3 restore LIFO");
        step(0, 1, 4'd0, 0, "R3 restore LIFO");

        while (m_banks < NB) step(1, 0, 4'd7, 1, "R2 fill banks");
        step(1, 0, 4'd9, 1, "R4 overflow with banks full");
        idle("R11 idle after overflow");
        step(0, 1, 4'd0, 0, "R3 read top bank 14");
        step(1, 0, 4'd9, 1, "R2 refill bank 14");

        for (int i = 0; i < 3; i++) step(1, 0, 4'd5, 0, "R5 spill to stack");
        step(1, 0, 4'd5, 1, "R4 overflow while spilled");
        step(1, 0, 4'd0, 0, "R8 level-0 save while spilled");
        for (int i = 0; i < 3; i++) step(0, 1, 4'd0, 0, "R6 stack drained first");
        step(0, 1, 4'd0, 0, "R3 bank 14 after stack drained");
        step(1, 0, 4'd4, 0, "R2 refill bank 14 again");

        while (m_stack < SMAX) step(1, 0, 4'd6, 0, "R5 spill to saturation");
        step(1, 0, 4'd6, 0, "R10 saturated stack overflows");
        step(1, 0, 4'd6, 0, "R10 saturated stack overflows again");
        while (m_stack > 0) step(0, 1, 4'd0, 0, "R6 drain saturated stack");
        while (m_banks > 0) step(0, 1, 4'd0, 0, "R3 drain banks");
        step(0, 1, 4'd0, 1, "R7 underflow after drain");
        step(1, 0, 4'd15, 0, "R2 first bank after drain");
        idle("R11 final idle");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule